// File: doc/BRIEF.md
# Tagged DMA Command Queue

This block collects DMA commands for a processing element that owns a local store, holds them while they wait, and hands them one at a time to a transfer engine. Software writes a command as five memory-mapped words: the local-store address, the low and high halves of the 64-bit effective address, a size/tag word, and a class/opcode word. It then reads the command-status word. That read is the enqueue attempt. A zero status means the command was accepted. A nonzero status means nothing changed and software must try again.

Accepted commands sit in one of 16 slots. Each carries a 5-bit tag that names its tag group. Plain commands may be issued and may complete in any order. A fence command waits until every older command of its tag group has completed. A barrier command waits in the same way, and it also holds back every younger command of its tag group until the barrier itself has been issued. Among all commands allowed to go, the oldest is offered to the engine first. The engine reports the slot of each finished transfer. The queue then frees that slot and emits a one-cycle completion pulse with the command's tag, which a tag-status unit can collect.

Top module: `dma_cmd_queue`

## Requirements
- R1: Register writes use regAddr 0 = local-store address, 1 = effective address bits 31:0, 2 = effective address bits 63:32, 3 = size in bits 31:16 and tag in bits 4:0, 4 = class in bits 31:16 (ignored) and opcode in the low bits. In the opcode, bit 0 = 1 selects put and 0 selects get, and bits 2:1 give the ordering (0 plain, 1 fence, 2 barrier, 3 illegal). An issued command presents exactly the fields that were written.
- R2: A one-cycle statRdEn pulse makes statValid high in the following cycle. statData then holds the result in bits 1:0 and zeros above it: 0 = accepted, 1 = queue full, 2 = illegal command.
- R3: Legal sizes are 1, 2, 4 and 8, and every multiple of 16 from 16 up to and including 16384. Any other size (0, 3, 24, 16400, ...) gives status 2 and enqueues nothing.
- R4: A size of 1, 2, 4 or 8 requires both addresses to be multiples of the size. Any larger size requires both addresses to be multiples of 16. Ordering code 3 is illegal. A violation gives status 2 and enqueues nothing.
- R5: The queue holds at most 16 commands. A legal attempt while all 16 slots are occupied gives status 1 and changes nothing. An illegal command gives status 2 even when the queue is full.
- R6: Among the commands allowed to issue, the oldest is offered first (issueValid with its fields), whatever slot it occupies. Plain commands never block one another.
- R7: A fence command is not issued while any older command with the same tag is still in the queue, whether issued or not.
- R8: A barrier command waits like a fence. No younger command with the same tag is issued before the barrier. Commands with other tags are not held back.
- R9: engDoneValid with engDoneSlot frees that slot. In the next cycle cplValid pulses for one cycle and cplTag carries that command's tag.
- R10: After reset the queue is empty, and statValid, issueValid and cplValid are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Command register write strobe |
| regAddr | input | 3 | Command register select |
| regWrData | input | 32 | Command register write data |
| statRdEn | input | 1 | Status read strobe; attempts the enqueue |
| statValid | output | 1 | Status result valid |
| statData | output | 32 | Status result, code in bits 1:0 |
| issueValid | output | 1 | A command is offered to the engine |
| issueReady | input | 1 | Engine accepts the offered command |
| issueSlot | output | 4 | Slot of the offered command |
| issueLsAddr | output | 32 | Local-store address |
| issueEffAddr | output | 64 | Effective address |
| issueSize | output | 16 | Transfer size in bytes |
| issueTag | output | 5 | Tag group |
| issuePut | output | 1 | 1 = put, 0 = get |
| engDoneValid | input | 1 | Engine finished a transfer |
| engDoneSlot | input | 4 | Slot of the finished transfer |
| cplValid | output | 1 | Completion pulse |
| cplTag | output | 5 | Tag of the completed command |

## Verification
The assertions check on every cycle that a status result only follows a status read, that a full queue never reports acceptance, that the offered slot is occupied and not yet issued, that a completion pulse only follows an engine report, and that the engine only reports issued slots. Only the bench scenarios can show the ordering outcomes: a fence held until older same-tag work completes, a barrier holding back younger same-tag work while other tags proceed, and oldest-first selection when a younger command occupies a lower slot. The exact size and alignment boundaries and the field contents of each issued command also depend on those scenarios.

// File: rtl/dmaq_pkg.sv
package dmaq_pkg;
  localparam int QDEPTH    = 16;
  localparam int SLOT_W    = $clog2(QDEPTH);
  localparam int TAG_W     = 5;
  localparam int SIZE_W    = 16;
  localparam int MAX_BYTES = 16384;
  localparam int LINE_B    = 16;
  localparam int LINE_W    = $clog2(LINE_B);
  localparam int ADDR_W    = 32;
  localparam int EA_W      = 64;

  localparam logic [2:0] REG_LSA   = 3'd0;
  localparam logic [2:0] REG_EALO  = 3'd1;
  localparam logic [2:0] REG_EAHI  = 3'd2;
  localparam logic [2:0] REG_SZTAG = 3'd3;
  localparam logic [2:0] REG_OPC   = 3'd4;

  typedef enum logic [1:0] {ORD_PLAIN = 2'd0, ORD_FENCE = 2'd1,
                            ORD_BARRIER = 2'd2, ORD_BAD = 2'd3} order_e;
  typedef enum logic [1:0] {ST_OK = 2'd0, ST_FULL = 2'd1,
                            ST_ILLEGAL = 2'd2} stat_e;

  typedef struct packed {
    logic [ADDR_W-1:0] lsAddr;
    logic [EA_W-1:0]   effAddr;
    logic [SIZE_W-1:0] size;
    logic [TAG_W-1:0]  tag;
    order_e            order;
    logic              put;
  } cmd_t;

  typedef struct packed {
    logic              enq;
    logic [SLOT_W-1:0] enqSlot;
    logic              issue;
    logic [SLOT_W-1:0] issueSlot;
    logic              done;
    logic [SLOT_W-1:0] doneSlot;
  } strobe_t;
endpackage

// File: rtl/dmaq_datapath.sv
module dmaq_datapath
  import dmaq_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [2:0]        regAddr,
  input  logic [31:0]       regWrData,
  input  strobe_t           stb,
  output logic              stagedLegal,
  output logic [TAG_W-1:0]  slotTag [QDEPTH],
  output order_e            slotOrder [QDEPTH],
  output logic [ADDR_W-1:0] issueLsAddr,
  output logic [EA_W-1:0]   issueEffAddr,
  output logic [SIZE_W-1:0] issueSize,
  output logic [TAG_W-1:0]  issueTag,
  output logic              issuePut
);
  cmd_t staged;
  cmd_t slotMem [QDEPTH];
  logic [SIZE_W-1:0] sizeMask;
  logic smallSize, sizeOk, alignOk;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      staged <= '0;
    end else if (regWrEn) begin
      case (regAddr)
        REG_LSA:   staged.lsAddr <= regWrData;
        REG_EALO:  staged.effAddr[31:0] <= regWrData;
        REG_EAHI:  staged.effAddr[63:32] <= regWrData;
        REG_SZTAG: begin
          staged.size <= regWrData[31:16];
          staged.tag  <= regWrData[TAG_W-1:0];
        end
        REG_OPC: begin
          staged.order <= order_e'(regWrData[2:1]);
          staged.put   <= regWrData[0];
        end
        default: ;
      endcase
    end
  end

  // size and alignment legality of the staged command
  always_comb begin
    sizeMask  = staged.size - SIZE_W'(1);
    smallSize = (staged.size == SIZE_W'(1)) || (staged.size == SIZE_W'(2)) ||
                (staged.size == SIZE_W'(4)) || (staged.size == SIZE_W'(8));
    if (smallSize) begin
      sizeOk  = 1'b1;
      alignOk = ((staged.lsAddr[SIZE_W-1:0] & sizeMask) == '0) &&
                ((staged.effAddr[SIZE_W-1:0] & sizeMask) == '0);
    end else begin
      sizeOk  = (staged.size[LINE_W-1:0] == '0) && (staged.size != '0) &&
                (staged.size <= SIZE_W'(MAX_BYTES));
      alignOk = (staged.lsAddr[LINE_W-1:0] == '0) &&
                (staged.effAddr[LINE_W-1:0] == '0);
    end
    stagedLegal = sizeOk && alignOk && (staged.order != ORD_BAD);
  end

  always_ff @(posedge clk) begin
    if (stb.enq) slotMem[stb.enqSlot] <= staged;
  end

  for (genvar i = 0; i < QDEPTH; i++) begin : g_slotOut
    assign slotTag[i]   = slotMem[i].tag;
    assign slotOrder[i] = slotMem[i].order;
  end

  assign issueLsAddr  = slotMem[stb.issueSlot].lsAddr;
  assign issueEffAddr = slotMem[stb.issueSlot].effAddr;
  assign issueSize    = slotMem[stb.issueSlot].size;
  assign issueTag     = slotMem[stb.issueSlot].tag;
  assign issuePut     = slotMem[stb.issueSlot].put;
endmodule

// File: rtl/dmaq_ctrl.sv
module dmaq_ctrl
  import dmaq_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              statRdEn,
  input  logic              stagedLegal,
  input  logic [TAG_W-1:0]  slotTag [QDEPTH],
  input  order_e            slotOrder [QDEPTH],
  input  logic              issueReady,
  input  logic              engDoneValid,
  input  logic [SLOT_W-1:0] engDoneSlot,
  output strobe_t           stb,
  output logic              statValid,
  output stat_e             statCode,
  output logic              issueValid,
  output logic              cplValid,
  output logic [TAG_W-1:0]  cplTag,
  output logic [QDEPTH-1:0] slotValid,
  output logic [QDEPTH-1:0] slotIssued
);
  // older[i][j] set: slot j holds a command older than slot i
  logic [QDEPTH-1:0] older [QDEPTH];
  logic [QDEPTH-1:0] eligible, oldest, barPend;
  logic [SLOT_W-1:0] freeSlot, selSlot;
  stat_e attemptCode;

  always_comb begin
    if (!stagedLegal)    attemptCode = ST_ILLEGAL;
    else if (&slotValid) attemptCode = ST_FULL;
    else                 attemptCode = ST_OK;
  end

  always_comb begin
    freeSlot = '0;
    for (int i = QDEPTH - 1; i >= 0; i--)
      if (!slotValid[i]) freeSlot = SLOT_W'(i);
  end

  for (genvar j = 0; j < QDEPTH; j++) begin : g_bar
    assign barPend[j] = slotValid[j] & ~slotIssued[j] & (slotOrder[j] == ORD_BARRIER);
  end

  for (genvar i = 0; i < QDEPTH; i++) begin : g_elig
    logic [QDEPTH-1:0] sameOlder;
    always_comb begin
      for (int j = 0; j < QDEPTH; j++)
        sameOlder[j] = older[i][j] & slotValid[j] & (slotTag[j] == slotTag[i]);
    end
    assign eligible[i] = slotValid[i] & ~slotIssued[i]
                       & ~((slotOrder[i] != ORD_PLAIN) & (|sameOlder))
                       & ~(|(sameOlder & barPend));
    assign oldest[i] = eligible[i] & ~(|(older[i] & eligible));
  end

  always_comb begin
    selSlot = '0;
    for (int i = 0; i < QDEPTH; i++)
      if (oldest[i]) selSlot = SLOT_W'(i);
  end

  assign issueValid    = |oldest;
  assign stb.enq       = statRdEn && (attemptCode == ST_OK);
  assign stb.enqSlot   = freeSlot;
  assign stb.issue     = issueValid && issueReady;
  assign stb.issueSlot = selSlot;
  assign stb.done      = engDoneValid;
  assign stb.doneSlot  = engDoneSlot;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      slotValid  <= '0;
      slotIssued <= '0;
      statValid  <= 1'b0;
      statCode   <= ST_OK;
      cplValid   <= 1'b0;
      cplTag     <= '0;
      for (int i = 0; i < QDEPTH; i++) older[i] <= '0;
    end else begin
      statValid <= statRdEn;
      if (statRdEn) statCode <= attemptCode;
      cplValid <= stb.done;
      if (stb.done) cplTag <= slotTag[stb.doneSlot];
      if (stb.enq) begin
        slotValid[stb.enqSlot]  <= 1'b1;
        slotIssued[stb.enqSlot] <= 1'b0;
        for (int i = 0; i < QDEPTH; i++) begin
          if (SLOT_W'(i) == stb.enqSlot) older[i] <= slotValid;
          else older[i][stb.enqSlot] <= 1'b0;
        end
      end
      if (stb.issue) slotIssued[stb.issueSlot] <= 1'b1;
      if (stb.done) begin
        slotValid[stb.doneSlot]  <= 1'b0;
        slotIssued[stb.doneSlot] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/dma_cmd_queue.sv
module dma_cmd_queue
  import dmaq_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [2:0]        regAddr,
  input  logic [31:0]       regWrData,
  input  logic              statRdEn,
  output logic              statValid,
  output logic [31:0]       statData,
  output logic              issueValid,
  input  logic              issueReady,
  output logic [SLOT_W-1:0] issueSlot,
  output logic [ADDR_W-1:0] issueLsAddr,
  output logic [EA_W-1:0]   issueEffAddr,
  output logic [SIZE_W-1:0] issueSize,
  output logic [TAG_W-1:0]  issueTag,
  output logic              issuePut,
  input  logic              engDoneValid,
  input  logic [SLOT_W-1:0] engDoneSlot,
  output logic              cplValid,
  output logic [TAG_W-1:0]  cplTag
);
  strobe_t           stb;
  logic              stagedLegal;
  logic [TAG_W-1:0]  slotTag [QDEPTH];
  order_e            slotOrder [QDEPTH];
  stat_e             statCode;
  logic [QDEPTH-1:0] slotValid, slotIssued;

  dmaq_datapath u_dp (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .stb(stb), .stagedLegal(stagedLegal),
    .slotTag(slotTag), .slotOrder(slotOrder), .issueLsAddr(issueLsAddr),
    .issueEffAddr(issueEffAddr), .issueSize(issueSize), .issueTag(issueTag),
    .issuePut(issuePut)
  );

  dmaq_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .statRdEn(statRdEn), .stagedLegal(stagedLegal),
    .slotTag(slotTag), .slotOrder(slotOrder), .issueReady(issueReady),
    .engDoneValid(engDoneValid), .engDoneSlot(engDoneSlot), .stb(stb),
    .statValid(statValid), .statCode(statCode), .issueValid(issueValid),
    .cplValid(cplValid), .cplTag(cplTag), .slotValid(slotValid),
    .slotIssued(slotIssued)
  );

  assign statData  = {30'd0, statCode};
  assign issueSlot = stb.issueSlot;
endmodule

// File: rtl/dmaq_checker.sv
module dmaq_checker
  import dmaq_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              statRdEn,
  input logic              statValid,
  input logic [31:0]       statData,
  input logic              issueValid,
  input logic [SLOT_W-1:0] issueSlot,
  input logic              engDoneValid,
  input logic [SLOT_W-1:0] engDoneSlot,
  input logic              cplValid,
  input logic [QDEPTH-1:0] slotValid,
  input logic [QDEPTH-1:0] slotIssued
);
  a_r2_stat_after_read: assert property (@(posedge clk) disable iff (!rstN)
    statValid |-> $past(statRdEn));

  a_r5_full_rejects: assert property (@(posedge clk) disable iff (!rstN)
    (statRdEn && (&slotValid)) |=> (statData[1:0] != 2'd0));

  a_r6_offer_pending: assert property (@(posedge clk) disable iff (!rstN)
    issueValid |-> (slotValid[issueSlot] && !slotIssued[issueSlot]));

  a_r9_cpl_after_done: assert property (@(posedge clk) disable iff (!rstN)
    cplValid |-> $past(engDoneValid));

  a_r9_done_of_issued: assert property (@(posedge clk) disable iff (!rstN)
    engDoneValid |-> slotIssued[engDoneSlot]);
endmodule

bind dma_cmd_queue dmaq_checker u_chk (
  .clk(clk), .rstN(rstN), .statRdEn(statRdEn), .statValid(statValid),
  .statData(statData), .issueValid(issueValid), .issueSlot(issueSlot),
  .engDoneValid(engDoneValid), .engDoneSlot(engDoneSlot), .cplValid(cplValid),
  .slotValid(slotValid), .slotIssued(slotIssued)
);

// File: tb/dma_cmd_queue_tb.sv
module dma_cmd_queue_tb;
  import dmaq_pkg::*;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [2:0]  regAddr = '0;
  logic [31:0] regWrData = '0;
  logic        statRdEn = 1'b0;
  logic        statValid;
  logic [31:0] statData;
  logic        issueValid;
  logic        issueReady = 1'b0;
  logic [3:0]  issueSlot;
  logic [31:0] issueLsAddr;
  logic [63:0] issueEffAddr;
  logic [15:0] issueSize;
  logic [4:0]  issueTag;
  logic        issuePut;
  logic        engDoneValid = 1'b0;
  logic [3:0]  engDoneSlot = '0;
  logic        cplValid;
  logic [4:0]  cplTag;

  dma_cmd_queue u_dut (.*);

  int checks = 0, fails = 0, issueCount = 0;

  typedef struct {
    logic [4:0] tag; logic [31:0] lsa; logic [63:0] ea;
    logic [15:0] size; logic put; string req;
  } expIss_t;
  typedef struct { logic [4:0] tag; string req; } expCpl_t;
  typedef struct { logic [3:0] slot; logic [4:0] tag; } fly_t;

  expIss_t expIssQ[$];
  expCpl_t expCplQ[$];
  fly_t    inflight[$];

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // monitor: compares issues and completions against the scoreboard
  initial begin
    expIss_t ei;
    expCpl_t ec;
    forever begin
      @(negedge clk);
      #1;
      if (rstN) begin
        if (issueValid && issueReady) begin
          issueCount++;
          inflight.push_back('{issueSlot, issueTag});
          if (expIssQ.size() == 0) check(1'b0, "R6", "unexpected issue tag", issueTag, 0);
          else begin
            ei = expIssQ.pop_front();
            check(issueTag == ei.tag && issueLsAddr == ei.lsa && issueEffAddr == ei.ea &&
                  issueSize == ei.size && issuePut == ei.put,
                  ei.req, "issued tag/lsa", {issueTag, issueLsAddr}, {ei.tag, ei.lsa});
          end
        end
        if (cplValid) begin
          if (expCplQ.size() == 0) check(1'b0, "R9", "unexpected completion tag", cplTag, 0);
          else begin
            ec = expCplQ.pop_front();
            check(cplTag == ec.tag, ec.req, "completion tag", cplTag, ec.tag);
          end
        end
      end
    end
  end

  task automatic wrReg(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk); regWrEn = 1'b0;
  endtask

  task automatic enqueue(input logic [31:0] lsa, input logic [63:0] ea,
                         input logic [15:0] size, input logic [4:0] tag,
                         input logic put, input logic [1:0] ord,
                         input logic [1:0] expCode, input string req);
    wrReg(3'd0, lsa);
    wrReg(3'd1, ea[31:0]);
    wrReg(3'd2, ea[63:32]);
    wrReg(3'd3, {size, 11'd0, tag});
    wrReg(3'd4, {16'hA5C3, 13'd0, ord, put});
    @(negedge clk); statRdEn = 1'b1;
    @(negedge clk); statRdEn = 1'b0;
    check(statValid && statData == {30'd0, expCode}, req, "status", statData, expCode);
  endtask

  task automatic pushIss(input logic [4:0] tag, input logic [31:0] lsa,
                         input logic [63:0] ea, input logic [15:0] size,
                         input logic put, input string req);
    expIssQ.push_back('{tag, lsa, ea, size, put, req});
  endtask

  task automatic complete(input int idx, input string req);
    fly_t f;
    @(negedge clk);
    f = inflight[idx];
    inflight.delete(idx);
    expCplQ.push_back('{f.tag, req});
    engDoneValid = 1'b1; engDoneSlot = f.slot;
    @(negedge clk); engDoneValid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finishRun();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog R10 actual=timeout expected=finish");
    finishRun();
  end

  initial begin
    int base;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R10 reset state
    check(!statValid, "R10", "statValid after reset", statValid, 0);
    check(!issueValid, "R10", "issueValid after reset", issueValid, 0);
    check(!cplValid, "R10", "cplValid after reset", cplValid, 0);

    // R1, R2, R3 legal commands, fields carried through, completion tags (R9)
    issueReady = 1'b1;
    pushIss(5'd7, 32'h100, 64'h1_0000_0200, 16'd64, 1'b1, "R1");
    enqueue(32'h100, 64'h1_0000_0200, 16'd64, 5'd7, 1'b1, 2'd0, 2'd0, "R2");
    pushIss(5'd1, 32'h104, 64'h8, 16'd4, 1'b0, "R1");
    enqueue(32'h104, 64'h8, 16'd4, 5'd1, 1'b0, 2'd0, 2'd0, "R4");
    pushIss(5'd2, 32'h0, 64'hFFFF_0000_0000_4000, 16'd16384, 1'b1, "R3");
    enqueue(32'h0, 64'hFFFF_0000_0000_4000, 16'd16384, 5'd2, 1'b1, 2'd0, 2'd0, "R3");
    idle(3);
    check(issueCount == 3, "R6", "plain commands all issued", issueCount, 3);
    complete(1, "R9");
    complete(0, "R9");
    complete(0, "R9");
    idle(3);

    // R3 / R4 illegal sizes, alignments and ordering code: nothing enqueued
    base = issueCount;
    enqueue(32'h0, 64'h0, 16'd3,     5'd9, 1'b0, 2'd0, 2'd2, "R3");
    enqueue(32'h0, 64'h0, 16'd24,    5'd9, 1'b0, 2'd0, 2'd2, "R3");
    enqueue(32'h0, 64'h0, 16'd0,     5'd9, 1'b0, 2'd0, 2'd2, "R3");
    enqueue(32'h0, 64'h0, 16'd16400, 5'd9, 1'b0, 2'd0, 2'd2, "R3");
    enqueue(32'h102, 64'h0, 16'd4,   5'd9, 1'b0, 2'd0, 2'd2, "R4");
    enqueue(32'h0, 64'h4, 16'd8,     5'd9, 1'b0, 2'd0, 2'd2, "R4");
    enqueue(32'h8, 64'h0, 16'd32,    5'd9, 1'b0, 2'd0, 2'd2, "R4");
    enqueue(32'h0, 64'h0, 16'd16,    5'd9, 1'b0, 2'd3, 2'd2, "R4");
    idle(3);
    check(!issueValid && issueCount == base, "R3", "illegal commands left queue empty",
          issueCount, base);

    // R5 fill all 16 slots, then a full rejection and illegal precedence
    issueReady = 1'b0;
    base = issueCount;
    for (int i = 0; i < QDEPTH; i++) begin
      pushIss(5'(i), 32'(i * 16), 64'(i * 32), 16'd16, 1'b0, "R5");
      enqueue(32'(i * 16), 64'(i * 32), 16'd16, 5'(i), 1'b0, 2'd0, 2'd0, "R5");
    end
    enqueue(32'h0, 64'h0, 16'd16, 5'd20, 1'b0, 2'd0, 2'd1, "R5");
    enqueue(32'h0, 64'h0, 16'd5,  5'd20, 1'b0, 2'd0, 2'd2, "R5");
    issueReady = 1'b1;
    idle(25);
    check(issueCount == base + QDEPTH, "R5", "issued count after fill",
          issueCount, base + QDEPTH);
    for (int i = 0; i < QDEPTH; i++) complete(0, "R9");
    idle(3);

    // R7 fence waits for an older same-tag command to complete
    base = issueCount;
    pushIss(5'd3, 32'h10, 64'h20, 16'd16, 1'b0, "R7");
    pushIss(5'd4, 32'h30, 64'h40, 16'd16, 1'b0, "R7");
    enqueue(32'h10, 64'h20, 16'd16, 5'd3, 1'b0, 2'd0, 2'd0, "R7");
    enqueue(32'h50, 64'h60, 16'd16, 5'd3, 1'b1, 2'd1, 2'd0, "R7");
    enqueue(32'h30, 64'h40, 16'd16, 5'd4, 1'b0, 2'd0, 2'd0, "R7");
    idle(3);
    check(issueCount == base + 2, "R7", "fence held while older same tag pending",
          issueCount, base + 2);
    pushIss(5'd3, 32'h50, 64'h60, 16'd16, 1'b1, "R7");
    complete(0, "R9");
    idle(3);
    check(issueCount == base + 3, "R7", "fence issued after completion",
          issueCount, base + 3);
    complete(0, "R9");
    complete(0, "R9");
    idle(3);

    // R8 barrier holds younger same-tag work, other tags proceed
    base = issueCount;
    pushIss(5'd5, 32'h100, 64'h100, 16'd32, 1'b0, "R8");
    pushIss(5'd6, 32'h400, 64'h400, 16'd16, 1'b0, "R8");
    enqueue(32'h100, 64'h100, 16'd32, 5'd5, 1'b0, 2'd0, 2'd0, "R8");
    enqueue(32'h200, 64'h200, 16'd16, 5'd5, 1'b1, 2'd2, 2'd0, "R8");
    enqueue(32'h300, 64'h300, 16'd16, 5'd5, 1'b0, 2'd0, 2'd0, "R8");
    enqueue(32'h400, 64'h400, 16'd16, 5'd6, 1'b0, 2'd0, 2'd0, "R8");
    idle(3);
    check(issueCount == base + 2, "R8", "barrier and younger same tag held",
          issueCount, base + 2);
    pushIss(5'd5, 32'h200, 64'h200, 16'd16, 1'b1, "R8");
    pushIss(5'd5, 32'h300, 64'h300, 16'd16, 1'b0, "R8");
    complete(0, "R9");
    idle(4);
    check(issueCount == base + 4, "R8", "barrier then younger issued",
          issueCount, base + 4);
    for (int i = 0; i < 3; i++) complete(0, "R9");
    idle(3);

    // R6 oldest first even when the younger command sits in a lower slot
    base = issueCount;
    pushIss(5'd11, 32'h200, 64'h300, 16'd16, 1'b0, "R6");
    enqueue(32'h200, 64'h300, 16'd16, 5'd11, 1'b0, 2'd0, 2'd0, "R6");
    idle(2);
    issueReady = 1'b0;
    enqueue(32'h210, 64'h310, 16'd16, 5'd12, 1'b1, 2'd0, 2'd0, "R6");
    complete(0, "R9");
    enqueue(32'h220, 64'h320, 16'd16, 5'd13, 1'b0, 2'd0, 2'd0, "R6");
    pushIss(5'd12, 32'h210, 64'h310, 16'd16, 1'b1, "R6");
    pushIss(5'd13, 32'h220, 64'h320, 16'd16, 1'b0, "R6");
    issueReady = 1'b1;
    idle(5);
    check(issueCount == base + 3, "R6", "both pending issued", issueCount, base + 3);
    complete(1, "R9");
    complete(0, "R9");
    idle(5);

    check(expIssQ.size() == 0, "R6", "expected issues left over", expIssQ.size(), 0);
    check(expCplQ.size() == 0, "R9", "expected completions left over", expCplQ.size(), 0);
    check(!cplValid && !issueValid, "R9", "idle after drain", {cplValid, issueValid}, 0);
    finishRun();
  end
endmodule